// File: doc/BRIEF.md
# Bus-Programmed Watchdog Timer

This block is a watchdog timer that software reaches through a small word-wide register interface. The interface has an address, a write strobe, a read strobe and a data bus. A programmable prescaler divides the system clock into a periodic tick, normally set to one millisecond. A tick counter advances on each tick while the watchdog runs. If software does not restart the count before it reaches a programmed limit, the block flags the expiry and, when asked to, raises a system reset pulse of fixed length.

Software first sets the limit and the divide value, then turns the watchdog on. After that it writes, at regular intervals, to a dedicated restart location, and the data of that write does not matter. The limit and the live count share one register, so one read is enough to compute the time left (limit minus count). Turning the watchdog off freezes the count and keeps every other setting.

Top module: `wdog_periph`

## Requirements
- R1: After reset all registers read as zero, `sys_rst_o` and `expired_o` are low, and the watchdog is stopped with a limit of 0.
- R2: The control register sits at offset 0x0. Its fields are: divide value in bits [17:0], run enable in bit 18, reset-drive select in bit 21, clock enable in bit 24 and prescaler enable in bit 25. These bits read back as written, and all other bits read as 0.
- R3: With divide value D in the control register, a tick occurs every D clock cycles, and a D of 0 acts as 1. The prescaler phase restarts from zero whenever run enable, clock enable or prescaler enable is clear.
- R4: No tick occurs, and the count does not move, unless run enable, clock enable and prescaler enable are all set.
- R5: The count rises by one per tick. Clearing run enable freezes the count and leaves the other control fields unchanged.
- R6: The limit/count register sits at offset 0x8. Bits [15:0] are the limit and can be written. Bits [31:16] read the live count. Writes to bits [31:16] are ignored, and writing the limit does not change the count.
- R7: Any write to offset 0xC, whatever its data, clears the count to 0 and clears `expired_o`.
- R8: The expiry fires on the tick that brings the count to the limit. Counted from the write that enables the watchdog, this happens limit×D clock edges later. At that point `expired_o` is set, and if bit 21 is set, `sys_rst_o` goes high for exactly 16 cycles.
- R9: With bit 21 clear, an expiry sets `expired_o` but never raises `sys_rst_o`.
- R10: When the reset pulse ends, the count returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no read is strobed |
| sys_rst_o | output | 1 | System reset pulse on expiry |
| expired_o | output | 1 | Sticky expiry flag, cleared by a restart write |

## Verification
The main function is driven by a table of divide value and limit pairs. The table includes a divide value of 0 next to a divide value of 1, and divisors that do not divide the limit evenly. Each pair therefore tests the expiry distance limit×D on its own, not only at divide 1. For each pair the bench also measures the width of the reset pulse and checks that the count is zero afterwards. Directed cases cover the rest:
- each of the three enable bits held off on its own;
- freezing the count while the settings stay in place;
- writes to the count half of the register, which must be ignored;
- restart writes with arbitrary data;
- re-enabling after the prescaler was part way through a period, which shows whether its phase restarted;
- expiry with the reset drive deselected.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int DIV_W  = 18;
  localparam int LIM_W  = 16;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_LIMCNT = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_KICK   = 4'hC;

  localparam int BIT_RUN    = 18;
  localparam int BIT_RSTSEL = 21;
  localparam int BIT_CLKON  = 24;
  localparam int BIT_DIVON  = 25;

  typedef struct packed {
    logic             div_on;
    logic             clk_on;
    logic             rst_sel;
    logic             run;
    logic [DIV_W-1:0] div;
  } ctrl_t;

  // Effective divisor: zero is treated as one.
  function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] d);
    return (d == '0) ? DIV_W'(1) : d;
  endfunction

  // Control register image as software sees it.
  function automatic logic [DATA_W-1:0] ctrl_word(input ctrl_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[DIV_W-1:0]  = c.div;
    w[BIT_RUN]    = c.run;
    w[BIT_RSTSEL] = c.rst_sel;
    w[BIT_CLKON]  = c.clk_on;
    w[BIT_DIVON]  = c.div_on;
    return w;
  endfunction

  // Ticks still to go before expiry.
  function automatic logic [LIM_W-1:0] ticks_left(input logic [LIM_W-1:0] lim,
                                                  input logic [LIM_W-1:0] cnt);
    return lim - cnt;
  endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LIM_W-1:0]  cnt_i,
  output ctrl_t             ctrl_o,
  output logic [LIM_W-1:0]  limit_o,
  output logic              kick_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic wr_ctrl, wr_lim;
  logic [DATA_W-1:0] rd_mux;
  logic unused_bits;

  assign wr_ctrl = wr_i && (addr_i == OFS_CTRL);
  assign wr_lim  = wr_i && (addr_i == OFS_LIMCNT);
  assign kick_o  = wr_i && (addr_i == OFS_KICK);

  assign unused_bits = ^{wdata_i[DATA_W-1:BIT_DIVON+1], wdata_i[BIT_CLKON-1:BIT_RSTSEL+1],
                         wdata_i[BIT_RSTSEL-1:BIT_RUN+1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_o  <= '0;
      limit_o <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_o.div     <= wdata_i[DIV_W-1:0];
        ctrl_o.run     <= wdata_i[BIT_RUN];
        ctrl_o.rst_sel <= wdata_i[BIT_RSTSEL];
        ctrl_o.clk_on  <= wdata_i[BIT_CLKON];
        ctrl_o.div_on  <= wdata_i[BIT_DIVON];
      end
      if (wr_lim) limit_o <= wdata_i[LIM_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      OFS_CTRL:   rd_mux = ctrl_word(ctrl_o);
      OFS_LIMCNT: rd_mux = {cnt_i, limit_o};
      default:    rd_mux = '0;
    endcase
  end

  assign rdata_o = rd_i ? rd_mux : '0;

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(ctrl_o)); // R5

endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         gate_i,
  input  logic [W-1:0] div_i,
  output logic         tick_o
);

  logic [W-1:0] phase;
  logic [W-1:0] last;

  assign last   = ((div_i == '0) ? W'(1) : div_i) - W'(1);
  assign tick_o = gate_i && (phase >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (!gate_i) phase <= '0;
    else if (tick_o)  phase <= '0;
    else              phase <= phase + W'(1);
  end

  AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_i |=> (phase == '0)); // R3

  AST_NO_TICK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_i) |-> !tick_o); // R4

endmodule

// File: rtl/wdog_expiry.sv
module wdog_expiry #(
  parameter int CNT_W     = 16,
  parameter int PULSE_LEN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             kick_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             rst_sel_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sys_rst_o,
  output logic             expired_o
);

  localparam int PW = $clog2(PULSE_LEN + 1);

  logic [PW-1:0] pls_cnt;
  logic pulse_act, pulse_end, hit, advance;

  assign pulse_act = (pls_cnt != '0);
  assign pulse_end = (pls_cnt == PW'(1));
  assign advance   = tick_i && !pulse_act;
  assign hit       = advance && !kick_i && (CNT_W'(cnt_o + 1'b1) == limit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o     <= '0;
      pls_cnt   <= '0;
      expired_o <= 1'b0;
    end else begin
      if (kick_i || pulse_end) cnt_o <= '0;
      else if (advance)        cnt_o <= cnt_o + 1'b1;

      if (hit)            pls_cnt <= PW'(PULSE_LEN);
      else if (pulse_act) pls_cnt <= pls_cnt - 1'b1;

      if (kick_i)   expired_o <= 1'b0;
      else if (hit) expired_o <= 1'b1;
    end
  end

  assign sys_rst_o = pulse_act && rst_sel_i;

  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> (cnt_o == '0)); // R7

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !kick_i && !pulse_act) |=> $stable(cnt_o)); // R5

  AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_act) |-> (expired_o || $past(kick_i))); // R8

  AST_CLEAR_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_act) |-> (cnt_o == '0)); // R10

endmodule

// File: rtl/wdog_periph.sv
module wdog_periph
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sys_rst_o,
  output logic              expired_o
);

  localparam int PULSE_LEN = 16;

  ctrl_t            ctrl;
  logic [LIM_W-1:0] limit, cnt;
  logic             kick, tick, gate;

  assign gate = ctrl.run && ctrl.clk_on && ctrl.div_on;

  wdog_regs regs_i (
    .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .wr_i(bus_wr), .rd_i(bus_rd),
    .wdata_i(bus_wdata), .cnt_i(cnt), .ctrl_o(ctrl), .limit_o(limit),
    .kick_o(kick), .rdata_o(bus_rdata)
  );

  wdog_prescaler #(.W(DIV_W)) pre_i (
    .clk(clk), .rst_n(rst_n), .gate_i(gate), .div_i(ctrl.div), .tick_o(tick)
  );

  wdog_expiry #(.CNT_W(LIM_W), .PULSE_LEN(PULSE_LEN)) exp_i (
    .clk(clk), .rst_n(rst_n), .run_i(gate), .tick_i(tick), .kick_i(kick),
    .limit_i(limit), .rst_sel_i(ctrl.rst_sel), .cnt_o(cnt),
    .sys_rst_o(sys_rst_o), .expired_o(expired_o)
  );

  AST_RST_IMPLIES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |-> expired_o); // R9

endmodule

// File: tb/wdog_periph_tb.sv
`timescale 1ns/1ps
module wdog_periph_tb_top;

  logic clk = 0, rst_n = 0;
  logic [3:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic sys_rst_o, expired_o;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  wdog_periph dut_i (.*);

  // divide value, limit, expected edges from enable to reset (limit * max(div,1))
  localparam int NV = 5;
  localparam int V_DIV [NV] = '{1, 0, 4, 7, 2};
  localparam int V_LIM [NV] = '{3, 3, 5, 2, 10};
  localparam int V_EXP [NV] = '{3, 3, 20, 14, 20};

  function automatic logic [31:0] mk_ctrl(int div, bit run, bit sel, bit ck, bit dv);
    logic [31:0] w = 32'(div) & 32'h3FFFF;
    w[18] = run; w[21] = sel; w[24] = ck; w[25] = dv;
    return w;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1; #0.5; d = bus_rdata; bus_rd = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, c1;
    int n;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(4'h0, d); chk("R1 ctrl", d, 0);
    rd(4'h8, d); chk("R1 limcnt", d, 0);
    chk("R1 sys_rst", {31'b0, sys_rst_o}, 0);
    chk("R1 expired", {31'b0, expired_o}, 0);

    // R2 control field readback
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, d); chk("R2 ctrl readback", d, 32'h0327_FFFF);
    wr(4'h0, 0); wr(4'hC, 0);

    // Table walk: R3 R8 R10
    for (int i = 0; i < NV; i++) begin
      wr(4'h0, 0); wr(4'hC, 0);
      wr(4'h8, V_LIM[i]);
      wr(4'h0, mk_ctrl(V_DIV[i], 1, 1, 1, 1));
      n = 0;
      do begin @(posedge clk); #1; n++; end while (!sys_rst_o && n < 1000);
      chk($sformatf("R8 R3 expiry distance vec%0d", i), n, V_EXP[i]);
      chk("R8 expired flag", {31'b0, expired_o}, 1);
      n = 1;
      forever begin @(posedge clk); #1; if (sys_rst_o) n++; else break; end
      chk("R8 pulse width", n, 16);
      rd(4'h8, d); chk("R10 count cleared after pulse", d[31:16], 0);
    end
    wr(4'h0, 0); wr(4'hC, 0);
    chk("R7 kick clears flag", {31'b0, expired_o}, 0);

    // R4 gating: each enable held off
    wr(4'h8, 1000);
    wr(4'h0, mk_ctrl(1, 1, 1, 0, 1));
    repeat (20) @(negedge clk);
    rd(4'h8, d); chk("R4 no clock enable", d[31:16], 0);
    wr(4'h0, mk_ctrl(1, 1, 1, 1, 0));
    repeat (20) @(negedge clk);
    rd(4'h8, d); chk("R4 no prescaler enable", d[31:16], 0);
    wr(4'h0, mk_ctrl(1, 0, 1, 1, 1));
    repeat (20) @(negedge clk);
    rd(4'h8, d); chk("R4 no run enable", d[31:16], 0);
    wr(4'h0, mk_ctrl(1, 1, 1, 1, 1));
    repeat (20) @(posedge clk);
    #1; rd(4'h8, d); chk("R5 R3 count after 20 ticks", d[31:16], 20);

    // R5 freeze with fields kept
    wr(4'h0, mk_ctrl(1, 0, 1, 1, 1));
    rd(4'h8, c1);
    repeat (10) @(negedge clk);
    rd(4'h8, d); chk("R5 count frozen", d[31:16], c1[31:16]);
    rd(4'h0, d); chk("R5 other fields kept", d, mk_ctrl(1, 0, 1, 1, 1));

    // R6 upper half ignored, limit write keeps count
    wr(4'h8, 32'hABCD_0005);
    rd(4'h8, d);
    chk("R6 limit written", d[15:0], 5);
    chk("R6 count unchanged", d[31:16], c1[31:16]);

    // R7 kick with arbitrary data while running
    wr(4'h8, 1000);
    wr(4'h0, mk_ctrl(1, 1, 1, 1, 1));
    repeat (5) @(negedge clk);
    wr(4'hC, 32'hDEAD_BEEF);
    rd(4'h8, d); chk("R7 kick data ignored", d[31:16], 0);

    // R3 prescaler phase restart
    wr(4'h0, mk_ctrl(4, 1, 1, 1, 1));
    repeat (2) @(negedge clk);
    wr(4'h0, mk_ctrl(4, 0, 1, 1, 1));
    wr(4'hC, 0);
    wr(4'h0, mk_ctrl(4, 1, 1, 1, 1));
    repeat (3) @(posedge clk);
    #1; rd(4'h8, d); chk("R3 no early tick after restart", d[31:16], 0);
    @(posedge clk); #1; rd(4'h8, d); chk("R3 tick after full period", d[31:16], 1);

    // R9 reset drive deselected
    wr(4'h0, 0); wr(4'hC, 0);
    wr(4'h8, 2);
    wr(4'h0, mk_ctrl(1, 1, 0, 1, 1));
    seen = 0;
    repeat (24) begin @(posedge clk); #1; if (sys_rst_o) seen = 1; end
    chk("R9 no reset output", {31'b0, seen}, 0);
    chk("R9 flag set", {31'b0, expired_o}, 1);
    wr(4'h0, 0); wr(4'hC, 32'h1234_5678);
    chk("R7 kick clears flag", {31'b0, expired_o}, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule